// File: doc/BRIEF.md
# Interrupt Acceptance Gate with Instruction Shadow

This block sits between the instruction decoder and the interrupt entry sequencer of a simple sequential CPU. At each completed instruction it decides whether a pending maskable or non-maskable request may be taken. Some instructions open a one-instruction shadow, during which no request is taken. These are loads of a segment register, either by move or by pop, and the prefix bytes (segment override, bus lock, repeat). A program can therefore change the stack segment and then the stack pointer with no interrupt in between. The shadow also holds off the non-maskable request, because software has no way to mask it around a stack switch.

Two kinds of instruction also accept requests in mid-flight: wait-test loops and repeated string operations. The decoder marks each completed wait test or string iteration with a step strobe. A step strobe is an acceptance point unless a segment-load shadow is active. The `narrow_mode` input selects the matching rule. With it low, a load of any segment register opens the shadow. With it high, only a load of the stack segment does.

Top module: `irq_gate`

## Requirements
- R1: A boundary whose opcode is 8'h8E (move to segment register) is a segment load. The target segment is the 2-bit `modrm_seg` input, with the stack segment encoded as 2'b10.
- R2: A boundary whose opcode matches 8'b000ss111 (pop into segment register) is a segment load. The target segment is opcode bits [4:3], so the stack segment form is 8'h17.
- R3: With `narrow_mode` low, every segment load opens the shadow. With `narrow_mode` high, only a load whose target segment is 2'b10 does; other segment loads act like ordinary instructions.
- R4: No request is accepted at the boundary of a shadow-opening instruction. The next boundary of an instruction that opens no shadow is an acceptance point. Back-to-back openers extend the shadow by one instruction each.
- R5: The prefix opcodes open the shadow. These are segment override 8'b001ss110, lock 8'hF0, and repeat 8'hF2 and 8'hF3.
- R6: The shadow blocks acceptance of the non-maskable request as well as the maskable one.
- R7: A `step` strobe is an acceptance point unless the last shadow-opening boundary was a segment load whose shadow is still open. A prefix shadow does not block step points.
- R8: The maskable request is accepted at an acceptance point only when `intr` and `int_en` are both high.
- R9: The non-maskable request is latched on a rising edge of `nmi`. It is held across blocked points, cleared when accepted, and takes priority over the maskable request.
- R10: After reset both acknowledge outputs are low. Each acknowledge is a single-cycle pulse, registered one clock after the acceptance point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_byte | input | 8 | Opcode of the instruction completing at `boundary` |
| modrm_seg | input | 2 | Segment field of the ModR/M byte for the move form |
| boundary | input | 1 | Instruction-complete strobe |
| step | input | 1 | Mid-instruction acceptance strobe (wait test or string iteration) |
| narrow_mode | input | 1 | 1: only stack-segment loads open the shadow |
| int_en | input | 1 | Maskable interrupt enable flag |
| intr | input | 1 | Maskable interrupt request (level) |
| nmi | input | 1 | Non-maskable interrupt request (edge) |
| nmi_ack | output | 1 | Non-maskable request accepted (one-cycle pulse) |
| intr_ack | output | 1 | Maskable request accepted (one-cycle pulse) |

## Verification
Suppose the shadow flag or its kind bit is stuck or stale. This shows one clock after the next step or boundary: an acknowledge is present where it should be absent, or absent where it should be present. The bench puts a known follow-up instruction after every opcode and segment-field pairing in both modes, so a stale flag shows at the second boundary of the pair. A lost or doubled non-maskable pending bit shows as a missing acknowledge at the first open point, or as a second acknowledge at the point after it.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int OP_W  = 8;
    localparam int SEG_W = 2;

    localparam logic [OP_W-1:0] OP_MOV_SEG = 8'h8E;
    localparam logic [OP_W-1:0] OP_LOCK    = 8'hF0;
    localparam logic [OP_W-1:0] OP_REPNZ   = 8'hF2;
    localparam logic [OP_W-1:0] OP_REPZ    = 8'hF3;

    typedef enum logic [SEG_W-1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_e;

    typedef enum logic {
        SH_PREFIX  = 1'b0,
        SH_SEGLOAD = 1'b1
    } shadow_kind_e;

    typedef struct packed {
        logic seg_load;
        logic prefix;
    } op_class_t;

    function automatic logic is_mov_seg(input logic [OP_W-1:0] op);
        return op == OP_MOV_SEG;
    endfunction

    function automatic logic is_pop_seg(input logic [OP_W-1:0] op);
        return (op[7:5] == 3'b000) && (op[2:0] == 3'b111);
    endfunction

    function automatic logic is_seg_override(input logic [OP_W-1:0] op);
        return (op[7:5] == 3'b001) && (op[2:0] == 3'b110);
    endfunction

    function automatic logic is_prefix(input logic [OP_W-1:0] op);
        return is_seg_override(op) || op == OP_LOCK ||
               op == OP_REPNZ || op == OP_REPZ;
    endfunction

endpackage

// File: rtl/irq_opclass.sv
module irq_opclass
    import irq_gate_pkg::*;
(
    input  logic [OP_W-1:0]  op_byte,
    input  logic [SEG_W-1:0] modrm_seg,
    input  logic             narrow_mode,
    output op_class_t        cls
);
    logic mov_f;
    logic pop_f;
    seg_e target;
    logic seg_ok;

    always_comb begin
        mov_f  = is_mov_seg(op_byte);
        pop_f  = is_pop_seg(op_byte);
        target = mov_f ? seg_e'(modrm_seg) : seg_e'(op_byte[4:3]);
        seg_ok = !narrow_mode || (target == SEG_STACK);
        cls.seg_load = (mov_f || pop_f) && seg_ok;
        cls.prefix   = is_prefix(op_byte);
    end
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow
    import irq_gate_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         boundary,
    input  op_class_t    cls,
    output logic         shadow_q,
    output shadow_kind_e kind_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= 1'b0;
            kind_q   <= SH_PREFIX;
        end else if (boundary) begin
            if (cls.seg_load) begin
                shadow_q <= 1'b1;
                kind_q   <= SH_SEGLOAD;
            end else if (cls.prefix) begin
                shadow_q <= 1'b1;
                kind_q   <= SH_PREFIX;
            end else begin
                shadow_q <= 1'b0;
                kind_q   <= SH_PREFIX;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic accept_pt,
    input  logic nmi,
    input  logic intr,
    input  logic int_en,
    output logic nmi_ack,
    output logic intr_ack
);
    logic nmi_prev;
    logic nmi_pend;
    logic take_nmi;
    logic take_intr;
    logic nmi_edge;

    always_comb begin
        nmi_edge  = nmi && !nmi_prev;
        take_nmi  = accept_pt && nmi_pend;
        take_intr = accept_pt && !nmi_pend && intr && int_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_ack  <= 1'b0;
            intr_ack <= 1'b0;
        end else begin
            nmi_prev <= nmi;
            nmi_pend <= (nmi_pend && !take_nmi) || nmi_edge;
            nmi_ack  <= take_nmi;
            intr_ack <= take_intr;
        end
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_byte,
    input  logic [SEG_W-1:0] modrm_seg,
    input  logic             boundary,
    input  logic             step,
    input  logic             narrow_mode,
    input  logic             int_en,
    input  logic             intr,
    input  logic             nmi,
    output logic             nmi_ack,
    output logic             intr_ack
);
    op_class_t    cls;
    logic         shadow_q;
    shadow_kind_e kind_q;
    logic         accept_pt;

    irq_opclass u_cls (
        .op_byte     (op_byte),
        .modrm_seg   (modrm_seg),
        .narrow_mode (narrow_mode),
        .cls         (cls)
    );

    irq_shadow u_sh (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .cls      (cls),
        .shadow_q (shadow_q),
        .kind_q   (kind_q)
    );

    always_comb begin
        if (boundary)
            accept_pt = !(cls.seg_load || cls.prefix);
        else
            accept_pt = step && !(shadow_q && kind_q == SH_SEGLOAD);
    end

    irq_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .accept_pt (accept_pt),
        .nmi       (nmi),
        .intr      (intr),
        .int_en    (int_en),
        .nmi_ack   (nmi_ack),
        .intr_ack  (intr_ack)
    );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] op_byte,
    input logic [1:0] modrm_seg,
    input logic       boundary,
    input logic       step,
    input logic       narrow_mode,
    input logic       int_en,
    input logic       intr,
    input logic       nmi,
    input logic       nmi_ack,
    input logic       intr_ack
);
    // R10 / R9: never both acknowledges at once
    p_single_ack_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_ack, intr_ack}));

    // R10: an acknowledge only follows a boundary or step strobe
    p_ack_needs_point_r10: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack || intr_ack) |-> $past(boundary || step));

    // R8: maskable acceptance needs request and enable
    p_intr_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        intr_ack |-> $past(intr && int_en));

    // R1 / R4 / R6: broad-mode move to segment blocks both acknowledges
    p_mov_shadow_r1: assert property (@(posedge clk) disable iff (rst)
        (boundary && op_byte == 8'h8E && !narrow_mode) |=> (!nmi_ack && !intr_ack));

    // R2 / R4: pop of stack segment blocks acceptance in either mode
    p_pop_ss_shadow_r2: assert property (@(posedge clk) disable iff (rst)
        (boundary && op_byte == 8'h17) |=> (!nmi_ack && !intr_ack));

    // R5: lock prefix blocks acceptance
    p_lock_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        (boundary && op_byte == 8'hF0) |=> (!nmi_ack && !intr_ack));

    // R10: pulses last one cycle when no further point follows
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (intr_ack && !boundary && !step) |=> !intr_ack);

    logic unused_ok;
    assign unused_ok = ^{modrm_seg, nmi};
endmodule

bind irq_gate irq_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_byte     (op_byte),
    .modrm_seg   (modrm_seg),
    .boundary    (boundary),
    .step        (step),
    .narrow_mode (narrow_mode),
    .int_en      (int_en),
    .intr        (intr),
    .nmi         (nmi),
    .nmi_ack     (nmi_ack),
    .intr_ack    (intr_ack)
);

// File: tb/tb_irq_gate.sv
module tb_irq_gate;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] op_byte;
    logic [1:0] modrm_seg;
    logic       boundary, step, narrow_mode, int_en, intr, nmi;
    logic       nmi_ack, intr_ack;
    logic       got_n, got_i;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_gate dut (
        .clk(clk), .rst(rst), .op_byte(op_byte), .modrm_seg(modrm_seg),
        .boundary(boundary), .step(step), .narrow_mode(narrow_mode),
        .int_en(int_en), .intr(intr), .nmi(nmi),
        .nmi_ack(nmi_ack), .intr_ack(intr_ack)
    );

    function automatic bit opens_shadow(logic [7:0] op, logic [1:0] ms, bit nar);
        bit mov, pop, pre;
        logic [1:0] tgt;
        mov = (op == 8'h8E);
        pop = (op[7:5] == 3'b000) && (op[2:0] == 3'b111);
        tgt = mov ? ms : op[4:3];
        pre = ((op[7:5] == 3'b001) && (op[2:0] == 3'b110)) ||
              op == 8'hF0 || op == 8'hF2 || op == 8'hF3;
        return ((mov || pop) && (!nar || tgt == 2'b10)) || pre;
    endfunction

    task automatic chk(string req, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    // drive one cycle from a negedge; sample registered outputs at next negedge
    task automatic cyc(bit b, bit s, logic [7:0] op, logic [1:0] ms);
        boundary  = b;
        step      = s;
        op_byte   = op;
        modrm_seg = ms;
        @(posedge clk);
        @(negedge clk);
        got_n    = nmi_ack;
        got_i    = intr_ack;
        boundary = 1'b0;
        step     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog got=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_byte = 8'h90; modrm_seg = 2'b00; boundary = 1'b0;
        step = 1'b0; narrow_mode = 1'b0; int_en = 1'b1; intr = 1'b0; nmi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset nmi_ack", nmi_ack, 1'b0);
        chk("R10 reset intr_ack", intr_ack, 1'b0);
        rst = 1'b0;

        // sweep R1 R2 R3 R4 R5 R8: every opcode, segment field and mode
        intr = 1'b1;
        for (int m = 0; m < 2; m++) begin
            narrow_mode = m[0];
            for (int op = 0; op < 256; op++) begin
                for (int ms = 0; ms < 4; ms++) begin
                    cyc(1'b1, 1'b0, op[7:0], ms[1:0]);
                    chk("R1/R2/R3/R5 opener boundary", got_i,
                        !opens_shadow(op[7:0], ms[1:0], m[0]));
                    cyc(1'b1, 1'b0, 8'h90, 2'b00);
                    chk("R4 follower boundary", got_i, 1'b1);
                end
            end
        end

        narrow_mode = 1'b0;
        // R4: back-to-back openers, one extra instruction each
        cyc(1'b1, 1'b0, 8'h8E, 2'b10); chk("R4 first opener", got_i, 1'b0);
        cyc(1'b1, 1'b0, 8'h17, 2'b00); chk("R4 second opener", got_i, 1'b0);
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R4 after chain", got_i, 1'b1);

        // R10: single-cycle pulse
        cyc(1'b0, 1'b0, 8'h90, 2'b00); chk("R10 pulse ends", got_i, 1'b0);

        // R8: enable low blocks maskable
        int_en = 1'b0;
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R8 int_en low", got_i, 1'b0);
        int_en = 1'b1; intr = 1'b0;
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R8 intr low", got_i, 1'b0);

        // R7: step points
        intr = 1'b1;
        cyc(1'b1, 1'b0, 8'hF3, 2'b00); chk("R5 rep prefix", got_i, 1'b0);
        cyc(1'b0, 1'b1, 8'hA4, 2'b00); chk("R7 step after prefix", got_i, 1'b1);
        cyc(1'b1, 1'b0, 8'h8E, 2'b10); chk("R1 opener before step", got_i, 1'b0);
        cyc(1'b0, 1'b1, 8'h9B, 2'b00); chk("R7 step in seg shadow", got_i, 1'b0);
        cyc(1'b1, 1'b0, 8'h9B, 2'b00); chk("R7 boundary after", got_i, 1'b1);
        cyc(1'b0, 1'b1, 8'h9B, 2'b00); chk("R7 step open", got_i, 1'b1);

        // R3: narrow mode ignores non-stack load; next step is open
        narrow_mode = 1'b1;
        cyc(1'b1, 1'b0, 8'h8E, 2'b11); chk("R3 narrow ds load", got_i, 1'b1);
        cyc(1'b0, 1'b1, 8'h9B, 2'b00); chk("R3 narrow step open", got_i, 1'b1);
        narrow_mode = 1'b0;

        // R6 / R9: NMI latched, blocked by shadow, priority, cleared
        intr = 1'b1;
        nmi = 1'b1;
        cyc(1'b0, 1'b0, 8'h90, 2'b00); chk("R9 no point no ack", got_n, 1'b0);
        nmi = 1'b0;
        cyc(1'b1, 1'b0, 8'h8E, 2'b00); chk("R6 nmi in shadow", got_n, 1'b0);
        chk("R6 intr in shadow", got_i, 1'b0);
        cyc(1'b1, 1'b0, 8'hF0, 2'b00); chk("R6 nmi at lock", got_n, 1'b0);
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R9 nmi held taken", got_n, 1'b1);
        chk("R9 priority over intr", got_i, 1'b0);
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R9 nmi cleared", got_n, 1'b0);
        chk("R9 intr after nmi", got_i, 1'b1);
        nmi = 1'b1;
        cyc(1'b0, 1'b0, 8'h90, 2'b00);
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R9 level held no re-edge a", got_n, 1'b1);
        cyc(1'b1, 1'b0, 8'h90, 2'b00); chk("R9 level held no re-edge b", got_n, 1'b0);
        nmi = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule